// File: doc/BRIEF.md
# Lane Metaframe Generator

This block assembles the metaframes of one lane of an Interlaken framing layer. Each metaframe opens with a synchronization control word and a scrambler-state control word, and it closes with a diagnostic control word. Every position between them carries either a payload word from an upstream show-ahead FIFO or a SKIP control word. The block produces one 64-bit word per clock cycle. Each word carries a 2-bit sync header and a control marker. A one-cycle pulse marks the cycle in which each metaframe's first word is presented.

Three inputs are sampled once per metaframe, at its first position: the metaframe length, the burst enable and the 2-bit lane status. The burst enable chooses whether the metaframe draws payload from the FIFO or sends SKIP words only. The lane status is carried into the diagnostic word of the same metaframe. The CRC32 field of the diagnostic word is taken from an input in the cycle the diagnostic word is built. Scrambling, CRC calculation and disparity control are done by neighbouring blocks.

Top module: `lane_mframe_gen`

## Requirements
- R1: While the reset is asserted, the word, header, control marker, start pulse and FIFO read strobe are all zero.
- R2: A metaframe of length L presents these words in order: position 0 is the sync word, position 1 is the scrambler-state word, positions 2 to L-2 are payload or skip words, and position L-1 is the diagnostic word. The start pulse is high exactly with position 0. Metaframes follow one another with no gap.
- R3: The length is taken from the 14-bit configuration input. A value below 4 gives a length of 4, and a value above 8192 gives a length of 8192.
- R4: In a metaframe whose latched burst enable is 1, a payload position with FIFO data available presents the FIFO head word with header 2'b01 and control marker 0. That word is read from the FIFO, and FIFO words appear in FIFO order.
- R5: In a metaframe whose latched burst enable is 0, every payload position carries a SKIP word, and no FIFO read is issued during the whole metaframe.
- R6: In a burst metaframe, a payload position whose FIFO is empty carries a SKIP word, and no read is issued for that position.
- R7: The burst enable is sampled only at the first position of each metaframe. A change later in the metaframe has no effect until the next metaframe.
- R8: The diagnostic word carries the lane status latched at the start of its metaframe in bits [33:32], the CRC input value in bits [31:0], and zeros in bits [57:34].
- R9: Control words carry header 2'b10 and control marker 1, with the type in bits [63:58]: 011110 for sync, 001010 for scrambler state, 000111 for skip and 011001 for diagnostic. The low 58 bits of the sync, scrambler-state and skip words are fixed fill values set by parameters.
- R10: The burst enable and lane status must stay unchanged from 5 cycles before to 5 cycles after each start pulse. A change made outside that window affects only the next metaframe.
- R11: A length change made during a metaframe takes effect at the start of the next metaframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_len | input | 14 | Requested metaframe length in words |
| fifo_data | input | 64 | Head word of the upstream FIFO (show-ahead) |
| fifo_avail | input | 1 | The FIFO holds at least one word |
| burst_en | input | 1 | Read payload (1) or send only SKIP words (0) for the next metaframe |
| lane_stat | input | 2 | Lane status to be placed in the diagnostic word |
| crc_in | input | 32 | CRC32 value for the diagnostic word |
| fifo_rd | output | 1 | Pops the FIFO head at the clock edge |
| tx_body | output | 64 | Outgoing word body |
| tx_hdr | output | 2 | Sync header of the outgoing word |
| tx_ctl | output | 1 | The outgoing word is a framing control word |
| mf_start | output | 1 | The outgoing word is the first word of a metaframe |

## Verification
Several rules are checked by assertions on every cycle:
- a read is never issued without available data, and never in a SKIP-only metaframe;
- the start pulse always comes with a sync word and is always followed by a scrambler-state word;
- the header stays one-hot once words flow;
- the position never reaches the latched length;
- the burst enable and lane status stay stable within the window around each pulse.

Only the bench's scenarios can show the rest:
- the exact position of the diagnostic word for each clamped length;
- the payload order and the alternation between data and skip when data is only sometimes available;
- that a burst, status or length change made in the middle of a metaframe reaches the output only in the following metaframe.

// File: rtl/mfg_pkg.sv
package mfg_pkg;

  // Sync header values
  localparam logic [1:0] HDR_CTL = 2'b10;
  localparam logic [1:0] HDR_DAT = 2'b01;

  // Control word type codes, bits [63:58]
  localparam logic [5:0] TY_SYNC = 6'b011110;
  localparam logic [5:0] TY_SCRM = 6'b001010;
  localparam logic [5:0] TY_SKIP = 6'b000111;
  localparam logic [5:0] TY_DIAG = 6'b011001;

  // Which kind of word the current metaframe position carries
  typedef enum logic [1:0] {
    SL_SYNC = 2'd0,
    SL_SCRM = 2'd1,
    SL_PAY  = 2'd2,
    SL_DIAG = 2'd3
  } slot_e;

endpackage

// File: rtl/mfg_slot_seq.sv
module mfg_slot_seq
  import mfg_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 8192,
  parameter int WIN     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             burst_en,
  input  logic [1:0]       lane_stat,
  output slot_e            slot,
  output logic             frame_begin,
  output logic             burst_q,
  output logic [1:0]       stat_q
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);
  localparam int               EXT_W = LEN_W + 1;

  logic [LEN_W-1:0] pos_q, pos_d;
  logic [LEN_W-1:0] len_q, len_d, len_clamped;
  logic             burst_d;
  logic [1:0]       stat_d;
  logic             last_pos;
  logic             armed_q;

  // Length clamp and next-state logic
  always_comb begin
    if (cfg_len < MIN_L)      len_clamped = MIN_L;
    else if (cfg_len > MAX_L) len_clamped = MAX_L;
    else                      len_clamped = cfg_len;

    frame_begin = (pos_q == '0);
    last_pos    = (pos_q == len_q - 1'b1);
    pos_d       = last_pos ? '0 : pos_q + 1'b1;
    len_d       = frame_begin ? len_clamped : len_q;
    burst_d     = frame_begin ? burst_en    : burst_q;
    stat_d      = frame_begin ? lane_stat   : stat_q;

    if (frame_begin)                   slot = SL_SYNC;
    else if (pos_q == LEN_W'(1))       slot = SL_SCRM;
    else if (last_pos)                 slot = SL_DIAG;
    else                               slot = SL_PAY;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      len_q   <= MIN_L;
      burst_q <= 1'b0;
      stat_q  <= 2'b00;
      armed_q <= 1'b0;
    end else begin
      pos_q   <= pos_d;
      len_q   <= len_d;
      burst_q <= burst_d;
      stat_q  <= stat_d;
      armed_q <= 1'b1;
    end
  end

  // Positions that fall within WIN cycles of a start pulse (the pulse is
  // registered, so it appears at position 1)
  logic in_win;
  assign in_win = (pos_q <= LEN_W'(WIN + 1)) ||
                  ((EXT_W'(pos_q) + EXT_W'(WIN)) > EXT_W'(len_q));

  // R2
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q < len_q);

  // R10
  burst_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && in_win) |-> $stable(burst_en));

  // R10
  stat_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && in_win) |-> $stable(lane_stat));

endmodule

// File: rtl/mfg_word_build.sv
module mfg_word_build
  import mfg_pkg::*;
#(
  parameter int          DATA_W    = 64,
  parameter int          CRC_W     = 32,
  parameter logic [57:0] SYNC_FILL = 58'h21E_6F82_AB55_0F0F,
  parameter logic [57:0] SCRM_FILL = 58'h000_0000_0000_0000,
  parameter logic [57:0] SKIP_FILL = 58'h21E_1E1E_1E1E_1E1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  slot_e             slot,
  input  logic              frame_begin,
  input  logic              burst_q,
  input  logic [1:0]        stat_q,
  input  logic              fifo_avail,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] tx_body,
  output logic [1:0]        tx_hdr,
  output logic              tx_ctl,
  output logic              mf_start
);

  localparam int TYPE_W = 6;
  localparam int FILL_W = DATA_W - TYPE_W;
  localparam int PAD_W  = FILL_W - 2 - CRC_W;

  logic [DATA_W-1:0] body_d;
  logic              ctl_d;
  logic [1:0]        hdr_d;
  logic              vld_q;

  // Word selection
  always_comb begin
    fifo_rd = 1'b0;
    ctl_d   = 1'b1;
    body_d  = {TY_SKIP, SKIP_FILL};
    unique case (slot)
      SL_SYNC: body_d = {TY_SYNC, SYNC_FILL};
      SL_SCRM: body_d = {TY_SCRM, SCRM_FILL};
      SL_DIAG: body_d = {TY_DIAG, {PAD_W{1'b0}}, stat_q, crc_in};
      SL_PAY: begin
        if (burst_q && fifo_avail) begin
          fifo_rd = 1'b1;
          ctl_d   = 1'b0;
          body_d  = fifo_data;
        end
      end
      default: body_d = {TY_SKIP, SKIP_FILL};
    endcase
    hdr_d = ctl_d ? HDR_CTL : HDR_DAT;
  end

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_body  <= '0;
      tx_hdr   <= 2'b00;
      tx_ctl   <= 1'b0;
      mf_start <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      tx_body  <= body_d;
      tx_hdr   <= hdr_d;
      tx_ctl   <= ctl_d;
      mf_start <= frame_begin;
      vld_q    <= 1'b1;
    end
  end

  // R6
  rd_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> fifo_avail);

  // R5
  no_rd_in_skip_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_q |-> !fifo_rd);

  // R2
  start_is_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> (tx_ctl && tx_body[DATA_W-1 -: TYPE_W] == TY_SYNC));

  // R2
  sync_then_scrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |=> (tx_hdr == HDR_CTL && tx_body[DATA_W-1 -: TYPE_W] == TY_SCRM));

  // R9
  hdr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $onehot(tx_hdr));

endmodule

// File: rtl/lane_mframe_gen.sv
module lane_mframe_gen
  import mfg_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 4,
  parameter int MAX_LEN = 8192,
  parameter int DATA_W  = 64,
  parameter int CRC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              fifo_avail,
  input  logic              burst_en,
  input  logic [1:0]        lane_stat,
  input  logic [CRC_W-1:0]  crc_in,
  output logic              fifo_rd,
  output logic [DATA_W-1:0] tx_body,
  output logic [1:0]        tx_hdr,
  output logic              tx_ctl,
  output logic              mf_start
);

  slot_e      slot;
  logic       frame_begin;
  logic       burst_q;
  logic [1:0] stat_q;

  mfg_slot_seq #(
    .LEN_W   (LEN_W),
    .MIN_LEN (MIN_LEN),
    .MAX_LEN (MAX_LEN),
    .WIN     (5)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_len     (cfg_len),
    .burst_en    (burst_en),
    .lane_stat   (lane_stat),
    .slot        (slot),
    .frame_begin (frame_begin),
    .burst_q     (burst_q),
    .stat_q      (stat_q)
  );

  mfg_word_build #(
    .DATA_W (DATA_W),
    .CRC_W  (CRC_W)
  ) i_build (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot        (slot),
    .frame_begin (frame_begin),
    .burst_q     (burst_q),
    .stat_q      (stat_q),
    .fifo_avail  (fifo_avail),
    .fifo_data   (fifo_data),
    .crc_in      (crc_in),
    .fifo_rd     (fifo_rd),
    .tx_body     (tx_body),
    .tx_hdr      (tx_hdr),
    .tx_ctl      (tx_ctl),
    .mf_start    (mf_start)
  );

endmodule

// File: tb/test_lane_mframe_gen.sv
module test_lane_mframe_gen;
  localparam int CLK_PERIOD = 10;
  localparam logic [57:0] SYNC_F = 58'h21E_6F82_AB55_0F0F;
  localparam logic [57:0] SCRM_F = 58'h000_0000_0000_0000;
  localparam logic [57:0] SKIP_F = 58'h21E_1E1E_1E1E_1E1E;

  logic        clk, rst_n;
  logic [13:0] cfg_len;
  logic [63:0] fifo_data;
  logic        fifo_avail, burst_en;
  logic [1:0]  lane_stat;
  logic [31:0] crc_in;
  logic        fifo_rd, tx_ctl, mf_start;
  logic [63:0] tx_body;
  logic [1:0]  tx_hdr;

  lane_mframe_gen i_lane_mframe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .fifo_data(fifo_data),
    .fifo_avail(fifo_avail), .burst_en(burst_en), .lane_stat(lane_stat),
    .crc_in(crc_in), .fifo_rd(fifo_rd), .tx_body(tx_body), .tx_hdr(tx_hdr),
    .tx_ctl(tx_ctl), .mf_start(mf_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Show-ahead FIFO model: an incrementing count
  logic [31:0] fcnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) fcnt <= 32'd0;
    else if (fifo_rd) fcnt <= fcnt + 32'd1;
  assign fifo_data = {~fcnt, fcnt};

  int errs = 0, checks = 0;
  int k, L, avail_mode;
  logic bf;
  logic [1:0] st;
  logic [31:0] exp_cnt;
  string tag_x = "";

  function automatic int clamp_len(input int c);
    return (c < 4) ? 4 : ((c > 8192) ? 8192 : c);
  endfunction

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic check(input string tag, input logic [67:0] got, input logic [67:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s%s k=%0d L=%0d got=%h exp=%h", tag, tag_x, k, L, got, exp);
    end
  endtask

  task automatic drive_next;
    case (avail_mode)
      0: fifo_avail = 1'b1;
      1: fifo_avail = (k % 2 == 1);
      default: fifo_avail = 1'b0;
    endcase
    crc_in = crc_in + 32'h0101_0103;
  endtask

  task automatic step;
    logic [63:0] eb;
    logic        ec;
    string       tg;
    @(posedge clk); #1;
    if (k == 0) begin
      L  = clamp_len(int'(cfg_len));
      bf = burst_en;
      st = lane_stat;
    end
    if (k == 0) begin eb = {6'b011110, SYNC_F}; ec = 1; tg = "R2 R3"; end
    else if (k == 1) begin eb = {6'b001010, SCRM_F}; ec = 1; tg = "R9"; end
    else if (k == L - 1) begin
      eb = {6'b011001, 24'd0, st, crc_in}; ec = 1; tg = "R8";
    end else if (bf && fifo_avail) begin
      eb = {~exp_cnt, exp_cnt}; ec = 0; tg = "R4"; exp_cnt++;
    end else begin
      eb = {6'b000111, SKIP_F}; ec = 1; tg = bf ? "R6" : "R5";
    end
    check(tg, {mf_start, tx_ctl, tx_hdr, tx_body},
          {(k == 0), ec, (ec ? 2'b10 : 2'b01), eb});
    if (k == L - 1)  // R5 R6: no reads beyond the payload words seen
      check("R5/R6 reads", {36'd0, fcnt}, {36'd0, exp_cnt});
    k = (k == L - 1) ? 0 : k + 1;
    drive_next();
  endtask

  task automatic do_reset;
    rst_n = 1'b0; k = 0; exp_cnt = 32'd0;
    repeat (3) @(posedge clk);
    #1;
    // R1: everything is zero while reset is held
    check("R1", {mf_start, tx_ctl, tx_hdr, tx_body}, 68'd0);
    check("R1 rd", {67'd0, fifo_rd}, 68'd0);
    drive_next();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int lens[9] = '{0, 1, 2, 3, 4, 5, 7, 16, 33};
    rst_n = 1'b0; cfg_len = 14'd8; burst_en = 1'b0; lane_stat = 2'd0;
    fifo_avail = 1'b0; crc_in = 32'h1234_5678; avail_mode = 0;

    // Sweep: length x burst x availability pattern
    for (int li = 0; li < 9; li++)
      for (int b = 0; b < 2; b++)
        for (int m = 0; m < 3; m++) begin
          cfg_len = 14'(lens[li]); burst_en = b[0]; lane_stat = 2'(li % 4);
          avail_mode = m;
          do_reset();
          repeat (2 * clamp_len(lens[li])) step();
        end

    // Mid-frame changes outside the stability window: R7 R10 R11
    cfg_len = 14'd24; burst_en = 1'b1; lane_stat = 2'd1; avail_mode = 1;
    do_reset();
    tag_x = " (mid-frame R7 R10 R11)";
    for (int c = 0; c < 6 * 40; c++) begin
      step();
      if (k == 10) lane_stat = lane_stat + 2'd1;
      if (k == 12) burst_en = ~burst_en;
      if (k == 14) cfg_len = (cfg_len == 14'd24) ? 14'd40 : 14'd24;
    end
    tag_x = "";

    // R3: longest metaframe, then clamp from above
    cfg_len = 14'd8192; burst_en = 1'b1; lane_stat = 2'd3; avail_mode = 0;
    do_reset();
    repeat (8192 + 4) step();
    cfg_len = 14'd12000; burst_en = 1'b0; lane_stat = 2'd2; avail_mode = 0;
    do_reset();
    repeat (8192 + 4) step();

    report();
  end
endmodule